// File: doc/BRIEF.md
# Tagged SECDED Memory Word Codec

This block guards one 128-bit memory word and a one-bit pointer tag with a single extended Hamming code. The tag is treated as a 129th information bit. It is covered by the same 9-bit check field that plain single-correct, double-detect protection of 128 bits already needs. The tag is held in one otherwise unused bit of the word's side-band ECC lane, so the data array keeps its 128 columns. Together, the check field and the tag make a 10-bit side field.

On a store, the encoder forms the side field from the data and a tag. The tag is 0 for an ordinary store. It is taken from a one-bit status flag only for a quadword store while the tags-active mode input is high. On a load, the decoder takes a stored word and side field. It returns the corrected data, the recovered tag, and whether a single error was repaired or an uncorrectable error was seen. A quadword load in tags-active mode copies the recovered tag back into the status flag. The pipeline can also write that flag directly. Encoding and decoding are combinational, and each result is registered once, so it is valid one cycle after its strobe.

Top module: `tagged_secded_codec`

## Requirements
- R1: After a synchronous reset, wr_valid, rd_valid, rd_tag, rd_corrected, rd_uncorrectable, tag_flag, wr_cw_data, wr_cw_side and rd_data are all 0.
- R2: Code layout. The 137 code positions are numbered from 1. Hamming bit k sits at position 2^k. The information bits fill the remaining positions in ascending order: data bit 0 first, then up to data bit 127, then the tag last, at position 137. Each side field bit k for k in 0..7 equals the XOR of the positions of all set information bits, taken bit k. Side bit 8 is the even parity over the 129 information bits and the 8 Hamming bits. Side bit 9 is the tag. The encoded word appears on wr_cw_data and wr_cw_side, with wr_valid high, exactly one cycle after wr_en.
- R3: A store with wr_quad low writes a tag of 0, whatever tags_active and tag_flag are.
- R4: A store with wr_quad and tags_active both high writes tag_flag, as sampled in the store cycle, as the tag. A quadword store with tags_active low writes 0.
- R5: A load of an error-free word returns the stored data and tag on rd_data and rd_tag, with both error flags low and rd_valid high, exactly one cycle after rd_en.
- R6: When any single one of the 138 stored bits is inverted, the load returns the original data and tag, with rd_corrected high and rd_uncorrectable low.
- R7: When any two distinct stored bits are inverted, the load raises rd_uncorrectable, keeps rd_corrected low and returns rd_tag as 0. An odd-parity syndrome above 137 is reported the same way.
- R8: A load with rd_quad and tags_active both high sets tag_flag to the returned rd_tag on the same edge that presents the result.
- R9: A load that is not a quadword load in tags-active mode leaves tag_flag unchanged, while rd_tag still shows the decoded tag.
- R10: flag_wr_en loads flag_wr_val into tag_flag on the next edge. A tag-copying load in the same cycle takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tags_active | input | 1 | Tags-active mode |
| wr_en | input | 1 | Store strobe |
| wr_quad | input | 1 | Store is a quadword store |
| wr_data | input | 128 | Store data |
| wr_valid | output | 1 | Encoded word valid |
| wr_cw_data | output | 128 | Encoded data part |
| wr_cw_side | output | 10 | Encoded side field {tag, parity, Hamming[7:0]} |
| rd_en | input | 1 | Load strobe |
| rd_quad | input | 1 | Load is a quadword load |
| rd_cw_data | input | 128 | Stored data part |
| rd_cw_side | input | 10 | Stored side field |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | 128 | Corrected data |
| rd_tag | output | 1 | Recovered tag (0 when uncorrectable) |
| rd_corrected | output | 1 | A single-bit error was repaired |
| rd_uncorrectable | output | 1 | Double or unlocatable error |
| flag_wr_en | input | 1 | Direct write of the status flag |
| flag_wr_val | input | 1 | Value for the direct write |
| tag_flag | output | 1 | Tag status flag |

## Verification
A wrong column position in the Hamming layout shows up in two ways. The encoded side field differs from the bench's arithmetic model one cycle after the store, and an inversion at that position is either repaired at the wrong bit or flagged uncorrectable one cycle after the load. The sweeps cover every single-bit inversion and every pair of inversions, so one misplaced column is exposed on that first result. A stale or wrongly updated status flag shows on tag_flag at the next sample after the load or flag write. It also shows in the tag of the following quadword store.

// File: rtl/tsec_pkg.sv
package tsec_pkg;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // smallest Hamming width that covers info_w information bits
  function automatic int ham_bits(input int info_w);
    int r;
    r = 1;
    while ((1 << r) < info_w + r + 1) r++;
    return r;
  endfunction

  // code position (from 1) of information bit idx: non-powers of two, ascending
  function automatic int info_pos(input int idx);
    int cnt;
    cnt = -1;
    for (int p = 1; p < 65536; p++) begin
      if (!is_pow2(p)) begin
        cnt++;
        if (cnt == idx) return p;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/tsec_hamgen.sv
module tsec_hamgen
  import tsec_pkg::*;
#(
  parameter int INFO_W = 129,
  parameter int HAM_W  = 8
) (
  input  logic [INFO_W-1:0] info,
  output logic [HAM_W-1:0]  ham
);
  logic [HAM_W-1:0] col [INFO_W];

  genvar i;
  for (i = 0; i < INFO_W; i++) begin : g_col
    localparam int POS = info_pos(i);
    assign col[i] = info[i] ? HAM_W'(POS) : '0;
  end

  always_comb begin
    ham = '0;
    for (int k = 0; k < INFO_W; k++) ham ^= col[k];
  end
endmodule

// File: rtl/tsec_encoder.sv
module tsec_encoder #(
  parameter int DATA_W = 128,
  parameter int HAM_W  = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              tag,
  output logic [HAM_W:0]    check
);
  logic [DATA_W:0]   info;
  logic [HAM_W-1:0]  ham;

  assign info = {tag, data};

  tsec_hamgen #(.INFO_W(DATA_W + 1), .HAM_W(HAM_W)) u_gen (
    .info (info),
    .ham  (ham)
  );

  assign check = {(^info) ^ (^ham), ham};
endmodule

// File: rtl/tsec_decoder.sv
module tsec_decoder
  import tsec_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int HAM_W  = 8
) (
  input  logic [DATA_W-1:0] cw_data,
  input  logic [HAM_W+1:0]  cw_side,
  output logic [DATA_W-1:0] data,
  output logic              tag,
  output logic              corrected,
  output logic              uncorrectable
);
  localparam int INFO_W = DATA_W + 1;
  localparam int TOT    = INFO_W + HAM_W;

  logic [INFO_W-1:0] info_rx, fix;
  logic [HAM_W-1:0]  ham_rx, ham_calc, syn;
  logic              par_rx, odd;

  assign info_rx = {cw_side[HAM_W+1], cw_data};
  assign ham_rx  = cw_side[HAM_W-1:0];
  assign par_rx  = cw_side[HAM_W];

  tsec_hamgen #(.INFO_W(INFO_W), .HAM_W(HAM_W)) u_gen (
    .info (info_rx),
    .ham  (ham_calc)
  );

  assign syn = ham_calc ^ ham_rx;
  assign odd = (^info_rx) ^ (^ham_rx) ^ par_rx;

  assign uncorrectable = (!odd && (syn != '0)) || (odd && (int'(syn) > TOT));
  assign corrected     = odd && !uncorrectable;

  genvar i;
  for (i = 0; i < INFO_W; i++) begin : g_fix
    localparam int POS = info_pos(i);
    assign fix[i] = corrected && (syn == HAM_W'(POS));
  end

  logic [INFO_W-1:0] info_ok;
  assign info_ok = info_rx ^ fix;
  assign data    = info_ok[DATA_W-1:0];
  assign tag     = info_ok[DATA_W] & ~uncorrectable;
endmodule

// File: rtl/tagged_secded_codec.sv
module tagged_secded_codec
  import tsec_pkg::*;
#(
  parameter  int DATA_W = 128,
  localparam int HAM_W  = ham_bits(DATA_W + 1),
  localparam int SIDE_W = HAM_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tags_active,
  input  logic              wr_en,
  input  logic              wr_quad,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_valid,
  output logic [DATA_W-1:0] wr_cw_data,
  output logic [SIDE_W-1:0] wr_cw_side,
  input  logic              rd_en,
  input  logic              rd_quad,
  input  logic [DATA_W-1:0] rd_cw_data,
  input  logic [SIDE_W-1:0] rd_cw_side,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_tag,
  output logic              rd_corrected,
  output logic              rd_uncorrectable,
  input  logic              flag_wr_en,
  input  logic              flag_wr_val,
  output logic              tag_flag
);
  logic              st_tag;
  logic [HAM_W:0]    st_check;
  logic [DATA_W-1:0] dec_data;
  logic              dec_tag, dec_corr, dec_ue, ld_copy;

  assign st_tag  = wr_quad && tags_active && tag_flag;
  assign ld_copy = rd_en && rd_quad && tags_active;

  tsec_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .data  (wr_data),
    .tag   (st_tag),
    .check (st_check)
  );

  tsec_decoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
    .cw_data       (rd_cw_data),
    .cw_side       (rd_cw_side),
    .data          (dec_data),
    .tag           (dec_tag),
    .corrected     (dec_corr),
    .uncorrectable (dec_ue)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid         <= 1'b0;
      wr_cw_data       <= '0;
      wr_cw_side       <= '0;
      rd_valid         <= 1'b0;
      rd_data          <= '0;
      rd_tag           <= 1'b0;
      rd_corrected     <= 1'b0;
      rd_uncorrectable <= 1'b0;
      tag_flag         <= 1'b0;
    end else begin
      wr_valid         <= wr_en;
      rd_valid         <= rd_en;
      rd_corrected     <= rd_en && dec_corr;
      rd_uncorrectable <= rd_en && dec_ue;
      if (wr_en) begin
        wr_cw_data <= wr_data;
        wr_cw_side <= {st_tag, st_check};
      end
      if (rd_en) begin
        rd_data <= dec_data;
        rd_tag  <= dec_tag;
      end
      if (ld_copy)         tag_flag <= dec_tag;
      else if (flag_wr_en) tag_flag <= flag_wr_val;
    end
  end

  // R2
  wr_valid_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> wr_valid);
  // R5
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  // R3
  plain_store_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_quad) |=> !wr_cw_side[SIDE_W-1]);
  // R7
  ue_tag_chk: assert property (@(posedge clk) disable iff (rst)
    rd_uncorrectable |-> (rd_valid && !rd_tag && !rd_corrected));
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_wr_en && !(rd_en && rd_quad && tags_active)) |=> $stable(tag_flag));
  // R8
  flag_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_quad && tags_active) |=> (tag_flag == rd_tag));
endmodule

// File: tb/tb_tagged_secded_codec.sv
module tb_tagged_secded_codec;
  localparam int DW = 128;
  localparam int SW = 10;
  localparam int CW = DW + SW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tags_active = 1'b0, wr_en = 1'b0, wr_quad = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 1'b0, rd_quad = 1'b0;
  logic [DW-1:0] rd_cw_data = '0;
  logic [SW-1:0] rd_cw_side = '0;
  logic flag_wr_en = 1'b0, flag_wr_val = 1'b0;
  logic wr_valid, rd_valid, rd_tag, rd_corrected, rd_uncorrectable, tag_flag;
  logic [DW-1:0] wr_cw_data, rd_data;
  logic [SW-1:0] wr_cw_side;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tagged_secded_codec dut (
    .clk(clk), .rst(rst), .tags_active(tags_active),
    .wr_en(wr_en), .wr_quad(wr_quad), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_cw_data(wr_cw_data), .wr_cw_side(wr_cw_side),
    .rd_en(rd_en), .rd_quad(rd_quad), .rd_cw_data(rd_cw_data), .rd_cw_side(rd_cw_side),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_tag(rd_tag),
    .rd_corrected(rd_corrected), .rd_uncorrectable(rd_uncorrectable),
    .flag_wr_en(flag_wr_en), .flag_wr_val(flag_wr_val), .tag_flag(tag_flag)
  );

  // arithmetic model of the code layout in R2
  function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d, input logic t);
    logic [DW:0] inf;
    logic [7:0]  h;
    int j;
    inf = {t, d};
    h = '0;
    j = 0;
    for (int p = 1; p <= 137; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (inf[j]) h ^= p[7:0];
        j++;
      end
    end
    return {t, (^inf) ^ (^h), h, d};
  endfunction

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [DW-1:0] d, input logic quad, input logic ta);
    @(negedge clk);
    wr_en = 1'b1; wr_quad = quad; tags_active = ta; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_quad = 1'b0; tags_active = 1'b0;
  endtask

  task automatic do_rd(input logic [CW-1:0] cw, input logic quad, input logic ta);
    @(negedge clk);
    rd_en = 1'b1; rd_quad = quad; tags_active = ta;
    rd_cw_data = cw[DW-1:0]; rd_cw_side = cw[CW-1:DW];
    @(negedge clk);
    rd_en = 1'b0; rd_quad = 1'b0; tags_active = 1'b0;
  endtask

  task automatic set_flag(input logic v);
    @(negedge clk);
    flag_wr_en = 1'b1; flag_wr_val = v;
    @(negedge clk);
    flag_wr_en = 1'b0;
  endtask

  function automatic logic [CW-1:0] rd_pack();
    return CW'({rd_valid, rd_uncorrectable, rd_corrected, rd_tag, rd_data});
  endfunction

  function automatic logic [CW-1:0] exp_pack(input logic ue, input logic co,
                                              input logic t, input logic [DW-1:0] d);
    return CW'({1'b1, ue, co, t, d});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] p1, p2, p3;
    logic [CW-1:0] cw;
    p1 = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
    p2 = ~p1;
    p3 = {4{32'hdead_beef}};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset flags", CW'({wr_valid, rd_valid, rd_tag, rd_corrected, rd_uncorrectable, tag_flag}), '0);
    chk("R1 reset data", {wr_cw_side, wr_cw_data}, '0);
    chk("R1 reset rd_data", CW'(rd_data), '0);

    // R2 encoding of ordinary stores: fixed patterns and walking ones
    do_wr(p1, 1'b0, 1'b0);
    chk("R2 enc p1", {wr_cw_side, wr_cw_data}, ref_enc(p1, 1'b0));
    chk("R2 wr_valid", CW'(wr_valid), CW'(1));
    do_wr(p2, 1'b0, 1'b0);
    chk("R2 enc p2", {wr_cw_side, wr_cw_data}, ref_enc(p2, 1'b0));
    do_wr('1, 1'b0, 1'b0);
    chk("R2 enc ones", {wr_cw_side, wr_cw_data}, ref_enc('1, 1'b0));
    for (int b = 0; b < DW; b++) begin
      do_wr(DW'(1) << b, 1'b0, 1'b0);
      chk("R2 enc walk", {wr_cw_side, wr_cw_data}, ref_enc(DW'(1) << b, 1'b0));
    end

    // R10 direct flag write
    set_flag(1'b1);
    chk("R10 flag write", CW'(tag_flag), CW'(1));
    // R4 quadword store in tags-active mode carries the flag
    do_wr(p3, 1'b1, 1'b1);
    chk("R4 quad ta store", {wr_cw_side, wr_cw_data}, ref_enc(p3, 1'b1));
    do_wr(p1, 1'b1, 1'b1);
    chk("R4 quad ta store p1", {wr_cw_side, wr_cw_data}, ref_enc(p1, 1'b1));
    do_wr(p3, 1'b1, 1'b0);
    chk("R4 quad no-ta store", {wr_cw_side, wr_cw_data}, ref_enc(p3, 1'b0));
    // R3 ordinary store with flag set and mode on
    do_wr(p3, 1'b0, 1'b1);
    chk("R3 plain store tag", {wr_cw_side, wr_cw_data}, ref_enc(p3, 1'b0));

    // R5 clean reads, R9 flag untouched by plain loads
    do_rd(ref_enc(p1, 1'b1), 1'b0, 1'b0);
    chk("R5 clean p1 t1", rd_pack(), exp_pack(1'b0, 1'b0, 1'b1, p1));
    do_rd(ref_enc(p2, 1'b0), 1'b0, 1'b0);
    chk("R5 clean p2 t0", rd_pack(), exp_pack(1'b0, 1'b0, 1'b0, p2));
    chk("R9 flag kept", CW'(tag_flag), CW'(1));
    do_rd(ref_enc(p2, 1'b0), 1'b1, 1'b0);
    chk("R9 quad no-ta flag kept", CW'({tag_flag, rd_tag}), CW'(2'b10));
    do_rd(ref_enc(p2, 1'b0), 1'b0, 1'b1);
    chk("R9 plain ta flag kept", CW'({tag_flag, rd_tag}), CW'(2'b10));

    // R6 every single inversion
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < CW; b++) begin
        cw = ref_enc(t[0] ? p1 : p2, t[0]) ^ (CW'(1) << b);
        do_rd(cw, 1'b0, 1'b0);
        chk("R6 single flip", rd_pack(), exp_pack(1'b0, 1'b1, t[0], t[0] ? p1 : p2));
      end
    end

    // R7 every pair of inversions; upper three result fields only
    for (int a = 0; a < CW; a++) begin
      for (int b = a + 1; b < CW; b++) begin
        cw = ref_enc(p3, 1'b1) ^ (CW'(1) << a) ^ (CW'(1) << b);
        do_rd(cw, 1'b0, 1'b0);
        chk("R7 double flip", CW'({rd_uncorrectable, rd_corrected, rd_tag}), CW'(3'b100));
      end
    end

    // R8 tag copy on quadword tags-active loads
    set_flag(1'b0);
    do_rd(ref_enc(p1, 1'b1), 1'b1, 1'b1);
    chk("R8 copy tag 1", CW'(tag_flag), CW'(1));
    do_rd(ref_enc(p1, 1'b0) ^ (CW'(1) << 5), 1'b1, 1'b1);
    chk("R8 copy tag 0 corrected", CW'(tag_flag), CW'(0));
    do_rd(ref_enc(p2, 1'b1) ^ (CW'(1) << 137), 1'b1, 1'b1);
    chk("R8 copy corrected tag", CW'({tag_flag, rd_corrected}), CW'(2'b11));
    do_rd(ref_enc(p2, 1'b1) ^ CW'(3), 1'b1, 1'b1);
    chk("R7 R8 ue forces flag 0", CW'({tag_flag, rd_uncorrectable}), CW'(2'b01));

    // R10 load copy beats same-cycle flag write
    @(negedge clk);
    flag_wr_en = 1'b1; flag_wr_val = 1'b1;
    rd_en = 1'b1; rd_quad = 1'b1; tags_active = 1'b1;
    cw = ref_enc(p3, 1'b0);
    rd_cw_data = cw[DW-1:0]; rd_cw_side = cw[CW-1:DW];
    @(negedge clk);
    flag_wr_en = 1'b0; rd_en = 1'b0; rd_quad = 1'b0; tags_active = 1'b0;
    chk("R10 load priority", CW'(tag_flag), CW'(0));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule